// File: doc/BRIEF.md
# Configurable Message FIFO Controller

This block is the message store behind one buffer of a CAN-style controller. It holds whole message words in a circular store whose usable depth comes from a 3-bit code, capped by a parameter that sets the physical storage. The same buffer serves one of two roles, chosen by a 2-bit mode field. In receive mode the protocol engine pushes frames in and software pops them out. In transmit mode software pushes frames in and the engine pops each one as it leaves on the bus.

Software sees the fill count, empty and full, a receive flag, a transmit flag and a sticky lost-message flag. Two interrupt requests are formed from these flags and their enables. The receive flag is raised either on every stored message or only when the fill level first reaches a programmable fraction of the depth. Disabling the buffer drops its contents. In transmit mode, when a frame is on the wire or queued next, the drop is held back until that frame's outcome is known. Configuration and interrupt enables are locked against writes except in the states allowed for them.

Top module: `msg_fifo_ctl`

## Requirements
- R1: Depth code 0 disables the buffer. Codes 1 to 7 select 4, 8, 16, 32, 48, 64 and 128 messages. A code whose depth exceeds MAX_DEPTH raises `cfg_err_o`. A request to enable is refused while `cfg_err_o` is 1 or the depth code is 0.
- R2: `cfg_err_o` is also 1 when the depth code is 1 and the threshold code is even (0, 2, 4 or 6), or when mode bit 1 is set. Mode 2'b00 is receive and 2'b01 is transmit.
- R3: A push into a full, enabled buffer is dropped. It sets `lost_o`, which stays 1 until `lost_clr_i` is pulsed.
- R4: Accepted words leave in arrival order. `count_o` tracks the stored words, `empty_o` means a count of 0, `full_o` means the count equals the selected depth, and `pop_data_o` shows the oldest word. A push is accepted only when the buffer is enabled and not full. A pop is accepted only when the buffer is not empty.
- R5: In receive mode with `cfg_isel` 0, `rx_flag_o` is set by the accepted push that takes the count before that push from below T to at least T. T = floor((code+1) x depth / 8), so code 7 means full.
- R6: In receive mode with `cfg_isel` 1, every accepted push sets `rx_flag_o`.
- R7: In transmit mode, every accepted pop sets `tx_flag_o`. `rxf_clr_i` and `txf_clr_i` clear their flags, and a set in the same cycle wins.
- R8: `rx_irq_o` equals the receive enable AND `rx_flag_o`. `tx_irq_o` equals the transmit enable AND `tx_flag_o`.
- R9: Writes to the interrupt enables are ignored while `en_o` is 1.
- R10: Mode, depth, threshold and source-select writes take effect only while `glob_reset_i` is 1, `en_o` is 0 and no deferred drop is pending.
- R11: Disabling in receive mode, or in transmit mode with `tx_busy_i` at 0, empties the buffer on that clock edge.
- R12: Disabling in transmit mode with `tx_busy_i` at 1 clears `en_o` but keeps the contents, and pushes are refused. The buffer empties on the edge where `tx_end_i` is 1.
- R13: `glob_reset_i` in receive mode, or `chan_reset_i` in transmit mode, clears `en_o` and empties the buffer. A request to enable is refused while `glob_reset_i` is 1, and in transmit mode also while `chan_reset_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_reset_i | input | 1 | Controller-wide reset state |
| chan_reset_i | input | 1 | Channel reset state |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode: 00 receive, 01 transmit |
| cfg_depth_i | input | 3 | Depth code |
| cfg_thr_i | input | 3 | Threshold fraction code |
| cfg_isel_i | input | 1 | Receive source: 0 threshold, 1 every message |
| ie_we_i | input | 1 | Interrupt-enable write strobe |
| rxie_i | input | 1 | Receive interrupt enable value |
| txie_i | input | 1 | Transmit interrupt enable value |
| en_we_i | input | 1 | Enable write strobe |
| en_i | input | 1 | Enable value |
| push_i | input | 1 | Store one word |
| push_data_i | input | DATA_W | Word to store |
| pop_i | input | 1 | Remove the oldest word |
| tx_busy_i | input | 1 | Head word is on the wire or next to go |
| tx_end_i | input | 1 | Frame outcome known (done, bus error, arbitration lost) |
| rxf_clr_i | input | 1 | Clear receive flag |
| txf_clr_i | input | 1 | Clear transmit flag |
| lost_clr_i | input | 1 | Clear lost flag |
| pop_data_o | output | DATA_W | Oldest stored word |
| count_o | output | CW | Stored word count |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | Count equals depth |
| en_o | output | 1 | Buffer enabled |
| cfg_err_o | output | 1 | Illegal configuration |
| rx_flag_o | output | 1 | Receive flag |
| tx_flag_o | output | 1 | Transmit flag |
| lost_o | output | 1 | Sticky lost-message flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
A slipped read or write pointer shows up at `pop_data_o` on the next clock. The reference queue predicts the oldest word every cycle, so a reorder or a lost word is caught within one cycle of the faulty store. A count that drifts from the pointers changes `full_o`, `empty_o` and the cycle on which the threshold flag rises, and the bench sees that at the first push or pop that follows. A missed or early flush, and a deferred drop that never resolves, leave words behind that the model has dropped, so they are visible at `count_o` one cycle after the disable, the reset or the `tx_end_i` pulse.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam logic [1:0] MODE_RX = 2'b00;
  localparam logic [1:0] MODE_TX = 2'b01;

  // message capacity selected by a depth code; 0 means unused
  function automatic int depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      3'd5:    return 48;
      3'd6:    return 64;
      default: return 128;
    endcase
  endfunction

  // fill level that meets the threshold: eighths of the depth, code 7 = full
  function automatic int thr_of(input logic [2:0] code, input int depth);
    return ((int'(code) + 1) * depth) / 8;
  endfunction

  // a four-message buffer only accepts odd threshold codes
  function automatic logic thr_legal(input logic [2:0] dcode, input logic [2:0] tcode);
    return !(dcode == 3'b001 && !tcode[0]);
  endfunction
endpackage

// File: rtl/msg_fifo_cfg.sv
module msg_fifo_cfg
  import mfc_pkg::*;
#(
  parameter int MAX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_open,
  input  logic       cfg_we,
  input  logic [1:0] mode_in,
  input  logic [2:0] dcode_in,
  input  logic [2:0] tcode_in,
  input  logic       isel_in,
  output logic [1:0] mode,
  output logic       isel,
  output logic [7:0] dep,
  output logic [7:0] thr,
  output logic       err
);
  logic [2:0] dcode_q, tcode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RX;
      isel    <= 1'b0;
      dcode_q <= 3'd0;
      tcode_q <= 3'd0;
    end else if (cfg_we && wr_open) begin
      mode    <= mode_in;
      isel    <= isel_in;
      dcode_q <= dcode_in;
      tcode_q <= tcode_in;
    end
  end

  always_comb begin
    dep = 8'(depth_of(dcode_q));
    thr = 8'(thr_of(tcode_q, depth_of(dcode_q)));
    err = (depth_of(dcode_q) > MAX_DEPTH) || !thr_legal(dcode_q, tcode_q) || mode[1];
  end
endmodule

// File: rtl/msg_fifo_store.sv
module msg_fifo_store #(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 16,
  localparam int PW = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        dep,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [MAX_DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p, input logic [7:0] d);
    return (int'(p) == int'(d) - 1) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr) wr_ptr <= step_ptr(wr_ptr, dep);
      if (rd) rd_ptr <= step_ptr(rd_ptr, dep);
      count <= count + CW'(wr) - CW'(rd);
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/msg_fifo_ctl.sv
module msg_fifo_ctl
  import mfc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_DEPTH = 16,
  localparam int CW = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_reset_i,
  input  logic              chan_reset_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [2:0]        cfg_depth_i,
  input  logic [2:0]        cfg_thr_i,
  input  logic              cfg_isel_i,
  input  logic              ie_we_i,
  input  logic              rxie_i,
  input  logic              txie_i,
  input  logic              en_we_i,
  input  logic              en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              tx_busy_i,
  input  logic              tx_end_i,
  input  logic              rxf_clr_i,
  input  logic              txf_clr_i,
  input  logic              lost_clr_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              en_o,
  output logic              cfg_err_o,
  output logic              rx_flag_o,
  output logic              tx_flag_o,
  output logic              lost_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  logic [1:0] mode;
  logic       isel;
  logic [7:0] dep, thr;
  logic       en_q, pend_q, rxie_q, txie_q, rxf_q, txf_q, lost_q;
  logic [CW-1:0] count;

  // named internal events
  logic is_rx, is_tx, usable, cfg_open;
  logic auto_clr, en_grant, en_drop, defer, flush;
  logic full_w, empty_w, push_ok, push_drop, pop_ok, rx_cross, rx_set, tx_set;

  msg_fifo_cfg #(.MAX_DEPTH(MAX_DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_open(cfg_open), .cfg_we(cfg_we_i),
    .mode_in(cfg_mode_i), .dcode_in(cfg_depth_i), .tcode_in(cfg_thr_i),
    .isel_in(cfg_isel_i), .mode(mode), .isel(isel), .dep(dep), .thr(thr),
    .err(cfg_err_o)
  );

  msg_fifo_store #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(push_ok), .rd(pop_ok),
    .wdata(push_data_i), .dep(dep), .rdata(pop_data_o), .count(count)
  );

  always_comb begin
    is_rx    = (mode == MODE_RX);
    is_tx    = (mode == MODE_TX);
    usable   = !cfg_err_o && (dep != 8'd0);
    cfg_open = glob_reset_i && !en_q && !pend_q;
    auto_clr = (is_rx && glob_reset_i) || (is_tx && chan_reset_i);
    en_grant = en_we_i && en_i && usable && !pend_q && !glob_reset_i &&
               (is_rx || (is_tx && !chan_reset_i));
    en_drop  = en_we_i && !en_i && en_q;
    defer    = en_drop && is_tx && tx_busy_i;
    flush    = auto_clr || (en_drop && !defer) || (pend_q && tx_end_i);
    full_w   = usable && (int'(count) == int'(dep));
    empty_w  = (count == '0);
    push_ok  = push_i && en_q && !full_w && !flush;
    push_drop = push_i && en_q && full_w && !flush;
    pop_ok   = pop_i && !empty_w && !flush;
    rx_cross = (int'(count) < int'(thr)) && (int'(count) + 1 >= int'(thr));
    rx_set   = is_rx && push_ok && (isel || rx_cross);
    tx_set   = is_tx && pop_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      rxie_q <= 1'b0;
      txie_q <= 1'b0;
      rxf_q  <= 1'b0;
      txf_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (auto_clr) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (en_grant)     en_q <= 1'b1;
        else if (en_drop) en_q <= 1'b0;
        if (defer)                   pend_q <= 1'b1;
        else if (pend_q && tx_end_i) pend_q <= 1'b0;
      end
      if (ie_we_i && !en_q) begin
        rxie_q <= rxie_i;
        txie_q <= txie_i;
      end
      if (rx_set)         rxf_q <= 1'b1;
      else if (rxf_clr_i) rxf_q <= 1'b0;
      if (tx_set)         txf_q <= 1'b1;
      else if (txf_clr_i) txf_q <= 1'b0;
      if (push_drop)       lost_q <= 1'b1;
      else if (lost_clr_i) lost_q <= 1'b0;
    end
  end

  assign count_o   = count;
  assign empty_o   = empty_w;
  assign full_o    = full_w;
  assign en_o      = en_q;
  assign rx_flag_o = rxf_q;
  assign tx_flag_o = txf_q;
  assign lost_o    = lost_q;
  assign rx_irq_o  = rxie_q && rxf_q;
  assign tx_irq_o  = txie_q && txf_q;
endmodule

// File: rtl/msg_fifo_chk.sv
module msg_fifo_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glob_reset_i,
  input logic          is_rx,
  input logic          is_tx,
  input logic          en_o,
  input logic          cfg_err_o,
  input logic [7:0]    dep,
  input logic [CW-1:0] count_o,
  input logic          empty_o,
  input logic          lost_o,
  input logic          tx_flag_o,
  input logic          push_drop,
  input logic          pop_ok,
  input logic          flush,
  input logic          rxie_q,
  input logic          txie_q
);
  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_o) <= int'(dep));

  assert_drop_sets_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> lost_o);

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty_o);

  assert_enable_needs_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> (!cfg_err_o && dep != 8'd0));

  assert_ie_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(en_o)) |-> ($stable(rxie_q) && $stable(txie_q)));

  assert_tx_pop_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && is_tx) |=> tx_flag_o);

  assert_global_clears_rx_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_reset_i && is_rx) |=> !en_o);

  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glob_reset_i) |-> $stable(cfg_err_o));
endmodule

bind msg_fifo_ctl msg_fifo_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_reset_i(glob_reset_i), .is_rx(is_rx),
  .is_tx(is_tx), .en_o(en_o), .cfg_err_o(cfg_err_o), .dep(dep),
  .count_o(count_o), .empty_o(empty_o), .lost_o(lost_o), .tx_flag_o(tx_flag_o),
  .push_drop(push_drop), .pop_ok(pop_ok), .flush(flush), .rxie_q(rxie_q),
  .txie_q(txie_q)
);

// File: tb/sim_msg_fifo_ctl.sv
`timescale 1ns/1ps
module sim_msg_fifo_ctl;
  localparam int DATA_W = 32;
  localparam int MAXD   = 16;
  localparam int CW     = $clog2(MAXD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glob_reset_i = 1'b1, chan_reset_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_isel_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'b00;
  logic [2:0] cfg_depth_i = 3'd0, cfg_thr_i = 3'd0;
  logic ie_we_i = 1'b0, rxie_i = 1'b0, txie_i = 1'b0;
  logic en_we_i = 1'b0, en_i = 1'b0;
  logic push_i = 1'b0, pop_i = 1'b0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic tx_busy_i = 1'b0, tx_end_i = 1'b0;
  logic rxf_clr_i = 1'b0, txf_clr_i = 1'b0, lost_clr_i = 1'b0;
  logic [DATA_W-1:0] pop_data_o;
  logic [CW-1:0] count_o;
  logic empty_o, full_o, en_o, cfg_err_o, rx_flag_o, tx_flag_o, lost_o, rx_irq_o, tx_irq_o;

  always #2.5 clk = ~clk;

  msg_fifo_ctl #(.DATA_W(DATA_W), .MAX_DEPTH(MAXD)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  logic [31:0] seq = 32'hC0DE_0000;

  // behavioural reference model
  logic [31:0] mq[$];
  bit m_en, m_pend, m_rxie, m_txie, m_rxf, m_txf, m_lost, m_isel;
  bit [1:0] m_mode;
  bit [2:0] m_dc, m_tc;
  int md, mthr;
  bit m_err, m_use, m_full, m_fl, m_pu, m_dr, m_po, m_rx, m_tx;

  function automatic int cap_of(input bit [2:0] c);
    int t[8] = '{0, 4, 8, 16, 32, 48, 64, 128};
    return t[c];
  endfunction

  function automatic bit model_err();
    return (cap_of(m_dc) > MAXD) || (m_dc == 3'd1 && m_tc[0] == 1'b0) || m_mode[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      {m_en, m_pend, m_rxie, m_txie, m_rxf, m_txf, m_lost, m_isel} = '0;
      m_mode = 2'b00; m_dc = 3'd0; m_tc = 3'd0;
    end else begin
      md    = cap_of(m_dc);
      mthr  = ((int'(m_tc) + 1) * md) / 8;
      m_err = model_err();
      m_use = !m_err && md != 0;
      m_full = m_use && mq.size() == md;
      m_rx = (m_mode == 2'b00);
      m_tx = (m_mode == 2'b01);
      m_fl = 1'b0;
      if ((m_rx && glob_reset_i) || (m_tx && chan_reset_i)) begin
        m_fl = 1'b1;
        if (m_pend) m_pend = 1'b0;
        m_en = 1'b0;
      end else begin
        if (m_pend && tx_end_i) begin m_fl = 1'b1; m_pend = 1'b0; end
        else if (en_we_i && en_i) begin
          if (m_use && !m_pend && !glob_reset_i && (m_rx || (m_tx && !chan_reset_i))) m_en = 1'b1;
        end else if (en_we_i && !en_i && m_en) begin
          m_en = 1'b0;
          if (m_tx && tx_busy_i) m_pend = 1'b1; else m_fl = 1'b1;
        end
      end
      m_pu = push_i && u_en_pre && !m_full && !m_fl;
      m_dr = push_i && u_en_pre && m_full && !m_fl;
      m_po = pop_i && mq.size() > 0 && !m_fl;
      if (m_rx && m_pu && (m_isel || (mq.size() < mthr && mq.size() + 1 >= mthr))) m_rxf = 1'b1;
      else if (rxf_clr_i) m_rxf = 1'b0;
      if (m_tx && m_po) m_txf = 1'b1;
      else if (txf_clr_i) m_txf = 1'b0;
      if (m_dr) m_lost = 1'b1;
      else if (lost_clr_i) m_lost = 1'b0;
      if (ie_we_i && !u_en_pre) begin m_rxie = rxie_i; m_txie = txie_i; end
      if (cfg_we_i && glob_reset_i && !u_en_pre && !u_pend_pre) begin
        m_mode = cfg_mode_i; m_dc = cfg_depth_i; m_tc = cfg_thr_i; m_isel = cfg_isel_i;
      end
      if (m_fl) mq.delete();
      else begin
        if (m_po) void'(mq.pop_front());
        if (m_pu) mq.push_back(push_data_i);
      end
      u_en_pre = m_en;
      u_pend_pre = m_pend;
    end
  end
  // model state as it stood before the current edge
  bit u_en_pre = 1'b0, u_pend_pre = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(int'(count_o) == mq.size(), "R4 count", count_o, mq.size());
      chk(empty_o == (mq.size() == 0), "R4 empty", empty_o, mq.size() == 0);
      chk(full_o == (!model_err() && cap_of(m_dc) != 0 && mq.size() == cap_of(m_dc)), "R4 full",
          full_o, mq.size());
      if (mq.size() > 0) chk(pop_data_o == mq[0], "R4 order", pop_data_o, mq[0]);
      chk(lost_o == m_lost, "R3 lost", lost_o, m_lost);
      chk(rx_flag_o == m_rxf, "R5 rx flag", rx_flag_o, m_rxf);
      chk(tx_flag_o == m_txf, "R7 tx flag", tx_flag_o, m_txf);
      chk(rx_irq_o == (m_rxie && m_rxf), "R8 rx irq", rx_irq_o, m_rxie && m_rxf);
      chk(tx_irq_o == (m_txie && m_txf), "R8 tx irq", tx_irq_o, m_txie && m_txf);
      chk(cfg_err_o == model_err(), "R2 cfg err", cfg_err_o, model_err());
      chk(en_o == m_en, "R13 enable", en_o, m_en);
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic cfg(input logic [1:0] mo, input logic [2:0] d, input logic [2:0] t, input logic s);
    cfg_we_i = 1'b1; cfg_mode_i = mo; cfg_depth_i = d; cfg_thr_i = t; cfg_isel_i = s;
    step(); cfg_we_i = 1'b0;
  endtask

  task automatic set_ie(input logic r, input logic t);
    ie_we_i = 1'b1; rxie_i = r; txie_i = t; step(); ie_we_i = 1'b0;
  endtask

  task automatic set_en(input logic v);
    en_we_i = 1'b1; en_i = v; step(); en_we_i = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      push_i = 1'b1; push_data_i = seq; seq = seq + 32'h0001_0003; step();
    end
    push_i = 1'b0;
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin pop_i = 1'b1; step(); end
    pop_i = 1'b0;
  endtask

  task automatic pulse_clr(input bit r, input bit t, input bit l);
    rxf_clr_i = r; txf_clr_i = t; lost_clr_i = l; step();
    rxf_clr_i = 1'b0; txf_clr_i = 1'b0; lost_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    cmp_on = 1'b1;
    chk(en_o == 1'b0 && empty_o == 1'b1, "R13 reset state", {en_o, empty_o}, 2'b01);
    chk(cfg_err_o == 1'b0, "R2 reset state", cfg_err_o, 0);

    // R2: four-message buffer with an even threshold code
    cfg(2'b00, 3'b001, 3'b010, 1'b0);
    chk(cfg_err_o == 1'b1, "R2 even threshold at depth 4", cfg_err_o, 1);
    cfg(2'b00, 3'b001, 3'b011, 1'b0);
    chk(cfg_err_o == 1'b0, "R2 odd threshold at depth 4", cfg_err_o, 0);
    // R1: 32 messages exceeds the 16-word cap
    cfg(2'b00, 3'b100, 3'b011, 1'b0);
    chk(cfg_err_o == 1'b1, "R1 depth above cap", cfg_err_o, 1);
    glob_reset_i = 1'b0; step();
    set_en(1'b1);
    chk(en_o == 1'b0, "R1 enable refused on bad config", en_o, 0);
    glob_reset_i = 1'b1; step();

    cfg(2'b00, 3'b011, 3'b011, 1'b0); // 16 messages, threshold 8
    set_ie(1'b1, 1'b1);
    set_en(1'b1);
    chk(en_o == 1'b0, "R13 enable refused in global reset", en_o, 0);
    glob_reset_i = 1'b0; step();
    cfg(2'b00, 3'b001, 3'b000, 1'b0);
    chk(cfg_err_o == 1'b0, "R10 config write ignored outside global reset", cfg_err_o, 0);
    set_en(1'b1);
    chk(en_o == 1'b1, "R13 enable granted", en_o, 1);
    set_ie(1'b0, 1'b0); // R9: must be ignored

    push_n(7);
    chk(rx_flag_o == 1'b0, "R5 below threshold", rx_flag_o, 0);
    push_n(1);
    chk(rx_flag_o == 1'b1, "R5 threshold crossed", rx_flag_o, 1);
    chk(rx_irq_o == 1'b1, "R9 enable write ignored while enabled", rx_irq_o, 1);
    pulse_clr(1'b1, 1'b0, 1'b0);
    chk(rx_flag_o == 1'b0 && rx_irq_o == 1'b0, "R7 R8 flag clear", {rx_flag_o, rx_irq_o}, 0);
    push_n(8);
    chk(full_o == 1'b1 && int'(count_o) == 16, "R4 full at 16", count_o, 16);
    chk(rx_flag_o == 1'b0, "R5 no retrigger above threshold", rx_flag_o, 0);
    push_n(1);
    chk(lost_o == 1'b1 && int'(count_o) == 16, "R3 push into full", {lost_o, count_o}, 6'h30);
    pop_n(3);
    pulse_clr(1'b0, 1'b0, 1'b1);
    chk(lost_o == 1'b0, "R3 lost cleared", lost_o, 0);
    set_en(1'b0);
    chk(empty_o == 1'b1, "R11 disable in receive flushes", count_o, 0);

    set_en(1'b1);
    push_n(2);
    glob_reset_i = 1'b1; step();
    chk(en_o == 1'b0 && empty_o == 1'b1, "R13 global reset clears receive", {en_o, count_o}, 0);

    // R6: every message raises the flag
    cfg(2'b00, 3'b001, 3'b001, 1'b1);
    glob_reset_i = 1'b0; step();
    set_en(1'b1);
    push_n(1);
    chk(rx_flag_o == 1'b1, "R6 per-message flag", rx_flag_o, 1);
    pulse_clr(1'b1, 1'b0, 1'b0);
    push_n(1);
    chk(rx_flag_o == 1'b1, "R6 second message", rx_flag_o, 1);
    pulse_clr(1'b1, 1'b0, 1'b0);

    // transmit mode, 8 messages
    glob_reset_i = 1'b1; step();
    cfg(2'b01, 3'b010, 3'b000, 1'b0);
    set_ie(1'b1, 1'b1);
    glob_reset_i = 1'b0; step();
    set_en(1'b1);
    chk(en_o == 1'b1, "R13 transmit enable", en_o, 1);
    push_n(8);
    chk(full_o == 1'b1 && int'(count_o) == 8, "R1 depth code 2 holds 8", count_o, 8);
    pop_n(1);
    chk(tx_flag_o == 1'b1 && tx_irq_o == 1'b1, "R7 R8 transmit flag", {tx_flag_o, tx_irq_o}, 3);
    pulse_clr(1'b0, 1'b1, 1'b0);
    tx_busy_i = 1'b1;
    set_en(1'b0);
    chk(en_o == 1'b0 && int'(count_o) == 7, "R12 deferred drop keeps words", count_o, 7);
    push_n(1);
    chk(int'(count_o) == 7, "R12 push refused while pending", count_o, 7);
    tx_end_i = 1'b1; step(); tx_end_i = 1'b0; tx_busy_i = 1'b0;
    chk(empty_o == 1'b1, "R12 flushed at frame end", count_o, 0);

    set_en(1'b1);
    push_n(2);
    set_en(1'b0);
    chk(empty_o == 1'b1, "R11 idle transmit disable flushes", count_o, 0);
    set_en(1'b1);
    push_n(2);
    chan_reset_i = 1'b1; step();
    chk(en_o == 1'b0 && empty_o == 1'b1, "R13 channel reset clears transmit", {en_o, count_o}, 0);
    set_en(1'b1);
    chk(en_o == 1'b0, "R13 enable refused in channel reset", en_o, 0);
    chan_reset_i = 1'b0; step();

    glob_reset_i = 1'b1; step();
    cfg(2'b10, 3'b010, 3'b000, 1'b0);
    chk(cfg_err_o == 1'b1, "R2 reserved mode", cfg_err_o, 1);
    cfg(2'b00, 3'b000, 3'b000, 1'b0);
    chk(cfg_err_o == 1'b0, "R1 unused depth is legal", cfg_err_o, 0);
    glob_reset_i = 1'b0; step();
    set_en(1'b1);
    chk(en_o == 1'b0, "R1 enable refused at depth 0", en_o, 0);
    push_n(1);
    chk(int'(count_o) == 0, "R1 no storage at depth 0", count_o, 0);
    step(); step();
    finish_run();
  end
endmodule